// File: doc/BRIEF.md
# ADC multiplexer frame sequencer

This block paces a multiplexed analog front end from a slow sample clock. Each frame holds a programmable number of conversion slots followed by one recovery cycle. A 4-bit slot-count input sets the number of slots. A 2-bit filter-length input sets each slot to one, two or three clock periods. The frame length is therefore 1 + slots × (width code + 1) cycles.

The sequencer marks the first cycle of every frame with a sync pulse, and a downstream compute engine starts one pass at that pulse. It raises a start strobe at the beginning of each slot. In the last cycle of each slot it presents a write strobe, with the slot number as the address and the converter result bus as write data, so a result RAM can capture the finished sample. A pass counter counts frames. The transfer-busy flag stays high for one whole frame out of every presample-count × sum-cycle-count frames.

Configuration is captured only in the first cycle of a frame. A setting changed partway through a frame therefore takes effect at the next frame.

Top module: `mux_seq_top`

## Requirements
- R1: A frame lasts 1 + div_i × (flen_i + 1) clock cycles, measured from one frame_sync_o pulse to the next. With div_i = 6 this gives 7, 13 and 19 cycles for flen_i = 0, 1 and 2.
- R2: An flen_i value of 3 produces the same slot width as the value 2.
- R3: Slot k (k = 0 … div_i−1) begins at frame cycle k × (flen_i + 1). In that cycle conv_start_o is 1 and slot_o equals k. conv_start_o is 1 in no other cycle.
- R4: The last cycle of each frame is the only cycle with settle_o = 1, and conv_start_o and wr_en_o are 0 in that cycle. With div_i = 0 a frame is a single settle cycle.
- R5: frame_sync_o is 1 exactly in the first cycle of each frame. That cycle is the start of slot 0 whenever div_i > 0.
- R6: wr_en_o is 1 in the last cycle of each slot and in no other cycle. In that cycle wr_addr_o equals the slot index and wr_data_o equals adc_data_i.
- R7: With N = presamps_i × sum_cycles_i, xfer_busy_o is 1 for one complete frame out of every N frames and does not change within a frame. N = 0 is treated as 1, so the flag is always 1.
- R8: div_i, flen_i, presamps_i and sum_cycles_i are sampled only in the first cycle of a frame. A change later in the frame does not alter that frame's length.
- R9: While rst_ni is low, and in the first cycle after it rises, frame_sync_o = 1, conv_start_o = 1 when div_i > 0, and slot_o = 0. The frame following reset is pass 0, so xfer_busy_o first rises in frame N−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 4 | Number of conversion slots per frame |
| flen_i | input | 2 | Slot width code: width = code + 1 cycles (3 acts as 2) |
| presamps_i | input | 4 | Presample count factor of the transfer period |
| sum_cycles_i | input | 4 | Sum-cycle count factor of the transfer period |
| adc_data_i | input | 16 | Converter result bus |
| frame_sync_o | output | 1 | First cycle of a frame / compute pass start |
| conv_start_o | output | 1 | First cycle of a conversion slot |
| slot_o | output | 4 | Current slot index |
| settle_o | output | 1 | Recovery cycle at frame end |
| wr_en_o | output | 1 | Result write strobe, last cycle of a slot |
| wr_addr_o | output | 4 | Result write address (slot index) |
| wr_data_o | output | 16 | Result write data |
| xfer_busy_o | output | 1 | Transfer-busy flag, one frame per period |

## Verification
Every output is a combinational function of the current state registers and the live inputs. Each result therefore belongs to the same cycle as the state that produces it. The bench samples 2 ns after each rising edge, changes adc_data_i, waits 1 ns, and compares every output against the frame cycle index it keeps itself. A configuration change lands one full frame late. The bench applies a change, waits for the next frame_sync_o, and only then measures a frame. For R8 it changes the settings mid-frame and expects the old length. Transfer-busy checks count frames, not cycles, starting from reset or from a sync-aligned point.

// File: rtl/mux_seq_pkg.sv
package mux_seq_pkg;
  localparam int unsigned WCODE_W = 2;
  typedef logic [WCODE_W-1:0] wcode_t;

  // code 3 folds onto the widest supported slot
  function automatic wcode_t clamp_wcode(input wcode_t f);
    return (f == 2'd3) ? 2'd2 : f;
  endfunction
endpackage

// File: rtl/mux_seq_timer.sv
module mux_seq_timer
  import mux_seq_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  wcode_t           flen_i,
  output logic             frame_start_o,
  output logic             settle_o,
  output logic             conv_start_o,
  output logic             conv_done_o,
  output logic [DIV_W-1:0] slot_o
);
  logic             start_q, settle_q;
  wcode_t           phase_q, w_q, cur_w;
  logic [DIV_W-1:0] slot_q, div_q, cur_div, last_slot;
  logic             settle_now;

  assign cur_div    = start_q ? div_i : div_q;
  assign cur_w      = start_q ? clamp_wcode(flen_i) : w_q;
  assign last_slot  = cur_div - DIV_W'(1);
  assign settle_now = start_q ? (cur_div == '0) : settle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b1;
      settle_q <= 1'b0;
      phase_q  <= '0;
      slot_q   <= '0;
      div_q    <= '0;
      w_q      <= '0;
    end else begin
      if (start_q) begin
        div_q <= div_i;
        w_q   <= clamp_wcode(flen_i);
      end
      start_q <= 1'b0;
      if (settle_now) begin
        start_q  <= 1'b1;
        settle_q <= 1'b0;
        phase_q  <= '0;
        slot_q   <= '0;
      end else if (phase_q == cur_w) begin
        phase_q <= '0;
        if (slot_q == last_slot) settle_q <= 1'b1;
        else                     slot_q   <= slot_q + DIV_W'(1);
      end else begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  assign frame_start_o = start_q;
  assign settle_o      = settle_now;
  assign conv_start_o  = !settle_now && (phase_q == '0);
  assign conv_done_o   = !settle_now && (phase_q == cur_w);
  assign slot_o        = slot_q;

  // R4
  settle_no_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |-> !conv_start_o && !conv_done_o);
  // R5
  sync_after_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |=> frame_start_o);
  // R3
  slot_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> slot_o < cur_div);
  // R3
  phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settle_o |-> phase_q <= cur_w);
  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_q |=> $stable(w_q) || start_q);
endmodule

// File: rtl/mux_seq_pass.sv
module mux_seq_pass #(
  parameter int unsigned PS_W = 4,
  parameter int unsigned SC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  logic            frame_end_i,
  input  logic [PS_W-1:0] presamps_i,
  input  logic [SC_W-1:0] sum_cycles_i,
  output logic            busy_o
);
  localparam int unsigned CNT_W = PS_W + SC_W;

  logic [CNT_W-1:0] n_in, n_q, n_cur, last_pass, pass_q;

  assign n_in      = CNT_W'(presamps_i) * CNT_W'(sum_cycles_i);
  assign n_cur     = frame_start_i ? n_in : n_q;
  assign last_pass = (n_cur == '0) ? '0 : n_cur - CNT_W'(1);
  assign busy_o    = pass_q >= last_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= '0;
      pass_q <= '0;
    end else begin
      if (frame_start_i) n_q <= n_in;
      if (frame_end_i)   pass_q <= busy_o ? '0 : pass_q + CNT_W'(1);
    end
  end

  // R7
  busy_frame_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |-> $stable(busy_o));
  // R7
  busy_wraps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && busy_o |=> pass_q == '0);
endmodule

// File: rtl/mux_seq_top.sv
module mux_seq_top
  import mux_seq_pkg::*;
#(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned PS_W   = 4,
  parameter int unsigned SC_W   = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        flen_i,
  input  logic [PS_W-1:0]   presamps_i,
  input  logic [SC_W-1:0]   sum_cycles_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              frame_sync_o,
  output logic              conv_start_o,
  output logic [DIV_W-1:0]  slot_o,
  output logic              settle_o,
  output logic              wr_en_o,
  output logic [DIV_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              xfer_busy_o
);
  logic frame_start, settle, conv_done;

  mux_seq_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .div_i         (div_i),
    .flen_i        (flen_i),
    .frame_start_o (frame_start),
    .settle_o      (settle),
    .conv_start_o  (conv_start_o),
    .conv_done_o   (conv_done),
    .slot_o        (slot_o)
  );

  mux_seq_pass #(.PS_W(PS_W), .SC_W(SC_W)) u_pass (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .frame_end_i   (settle),
    .presamps_i    (presamps_i),
    .sum_cycles_i  (sum_cycles_i),
    .busy_o        (xfer_busy_o)
  );

  assign frame_sync_o = frame_start;
  assign settle_o     = settle;
  assign wr_en_o      = conv_done;
  assign wr_addr_o    = slot_o;
  assign wr_data_o    = adc_data_i;

  // R6
  wr_not_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !settle_o);
  // R6
  wr_then_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> conv_start_o || settle_o);
endmodule

// File: tb/mux_seq_top_bench.sv
module mux_seq_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  div_i = 4'd6;
  logic [1:0]  flen_i = 2'd0;
  logic [3:0]  presamps_i = 4'd1;
  logic [3:0]  sum_cycles_i = 4'd3;
  logic [15:0] adc_data_i = '0;
  logic        frame_sync_o, conv_start_o, settle_o, wr_en_o, xfer_busy_o;
  logic [3:0]  slot_o, wr_addr_o;
  logic [15:0] wr_data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  mux_seq_top u_mux_seq_top (.*);

  // {div, flen, expected frame length}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {4'd6,  2'd0, 8'd7},
    {4'd6,  2'd1, 8'd13},
    {4'd6,  2'd2, 8'd19},
    {4'd6,  2'd3, 8'd19},
    {4'd0,  2'd1, 8'd1},
    {4'd1,  2'd0, 8'd2},
    {4'd15, 2'd2, 8'd46},
    {4'd3,  2'd1, 8'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic wait_sync();
    do step(); while (!frame_sync_o);
  endtask

  // entered in a sync cycle; leaves in the next sync cycle
  task automatic run_frame(input int d, input int w, input int exp_len);
    int len = 0, convs = 0, wrs = 0, sets = 0, errs = 0;
    do begin
      adc_data_i = 16'(len * 37 + 5);
      #1;
      if (len == 0 && frame_sync_o !== 1'b1) errs++;
      if (len != 0 && frame_sync_o) errs++;
      if (conv_start_o) begin
        if (len != convs * w || slot_o != 4'(convs)) errs++;
        convs++;
      end
      if (wr_en_o) begin
        if (len + 1 != (wrs + 1) * w || wr_addr_o != 4'(wrs) ||
            wr_data_o != adc_data_i) errs++;
        wrs++;
      end
      if (settle_o) begin
        sets++;
        if (len != exp_len - 1 || conv_start_o || wr_en_o) errs++;
      end
      len++;
      step();
    end while (!frame_sync_o && len < 100);
    // R1 R2
    chk(len == exp_len, "R1/R2 frame length", len, exp_len);
    // R3
    chk(convs == d, "R3 slot starts", convs, d);
    // R6
    chk(wrs == d, "R6 writes", wrs, d);
    // R4
    chk(sets == 1, "R4 settle count", sets, 1);
    // R5
    chk(errs == 0, "R3/R4/R5/R6 in-frame timing", errs, 0);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    if (!done) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f1, f2, nb;
    repeat (3) @(posedge clk_i);
    #1;
    // R9 reset state
    chk(frame_sync_o && conv_start_o && slot_o == 0, "R9 in reset", slot_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(frame_sync_o && conv_start_o && slot_o == 0, "R9 after release", frame_sync_o, 1);
    chk(xfer_busy_o == 1'b0, "R9 pass 0 not busy (N=3)", xfer_busy_o, 0);
    // frames 0,1 idle, frame 2 busy
    for (int k = 0; k < 3; k++) begin
      chk(xfer_busy_o == (k == 2), "R9/R7 first busy frame", xfer_busy_o, k == 2);
      run_frame(6, 1, 7);
    end

    for (int i = 0; i < NV; i++) begin
      div_i  = VEC[i][13:10];
      flen_i = VEC[i][9:8];
      wait_sync();
      run_frame(int'(VEC[i][13:10]),
                (VEC[i][9:8] == 2'd3) ? 3 : int'(VEC[i][9:8]) + 1,
                int'(VEC[i][7:0]));
    end

    // R8: mid-frame change keeps current length
    div_i = 4'd6; flen_i = 2'd1;
    wait_sync();
    begin
      int len = 0;
      do begin
        if (len == 3) begin div_i = 4'd2; flen_i = 2'd0; end
        len++;
        step();
      end while (!frame_sync_o && len < 100);
      chk(len == 13, "R8 mid-frame change ignored", len, 13);
    end
    run_frame(2, 1, 3);

    // R7: N = 6 period
    div_i = 4'd1; flen_i = 2'd0; presamps_i = 4'd2; sum_cycles_i = 4'd3;
    wait_sync();
    wait_sync();
    f1 = -1; f2 = -1; nb = 0;
    for (int k = 0; k < 14; k++) begin
      if (xfer_busy_o) begin
        nb++;
        if (f1 < 0) f1 = k; else if (f2 < 0) f2 = k;
      end
      step();
      chk(!frame_sync_o && xfer_busy_o == (f1 == k || f2 == k) || frame_sync_o,
          "R7 busy stable in frame", xfer_busy_o, 1);
      step();
    end
    chk(f2 - f1 == 6, "R7 busy period", f2 - f1, 6);
    chk(nb >= 2 && nb <= 3, "R7 busy frame count", nb, 2);

    // R7: N = 0 treated as 1
    presamps_i = 4'd0;
    wait_sync();
    wait_sync();
    for (int k = 0; k < 4; k++) begin
      chk(xfer_busy_o == 1'b1, "R7 zero product always busy", xfer_busy_o, 1);
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule